// File: doc/BRIEF.md
# Watchdog Timer with Wake-up Stabilization Delay

This block is a slow 8-bit up-counter fed by a selectable prescaler, and it has two jobs. While the CPU runs, it is a watchdog. Firmware must clear the count from time to time. If the count wraps past its top value while the watchdog is armed, the block issues a one-cycle reset request to the chip's reset controller.

When the part leaves its low-power stop state, the block also acts as an oscillator settling timer. This happens after a wake interrupt and after every reset. The count restarts from zero and the CPU clock enable stays low. The enable rises only when the count carries out of bit 3, which is after sixteen prescaled ticks.

The watchdog can be turned off with exactly one 4-bit code in the upper nibble of the control byte. Reset always clears the control byte, so the watchdog comes up armed and uses the slowest prescaler ratio.

Top module: `wdog_stab`

## Requirements
- R1: Reset (rst_n low) drives cpu_clk_en and rst_req low. It clears the control byte, so after reset the watchdog is armed and prescaler select 2'b00 is in use.
- R2: Reset release starts a settling interval at the DIV0 rate. cpu_clk_en rises exactly 16*DIV0 clock cycles after the first clock edge with rst_n high.
- R3: Control byte bits [3:2] choose the prescaler ratio: 2'b00 gives DIV0, 2'b01 gives DIV1, 2'b10 gives DIV2 and 2'b11 gives DIV3. The counter advances once every that many clock cycles.
- R4: A control write with bit 1 set zeroes the counter and the prescaler on that clock edge. Regular clears therefore keep rst_req low.
- R5: With the watchdog armed, the counter wrapping from 255 to 0 raises rst_req for exactly one cycle. This happens on the edge after the wrapping tick, which is 256*DIV clock cycles after a clear.
- R6: The watchdog is off only while control bits [7:4] equal 4'b1010. Then the counter wraps with no request. Any other nibble, for example 4'b1011 or 4'b0000, arms it.
- R7: stop_req sampled high while cpu_clk_en is high enters stop. cpu_clk_en drops on that edge, and the counter and prescaler hold their values with no request.
- R8: wake_irq sampled high in stop zeroes the counter and prescaler and starts a settling interval at the programmed prescaler rate. cpu_clk_en rises 16*DIV cycles after that edge, and the count then carries on from 16.
- R9: Control writes are ignored while cpu_clk_en is low. This covers the clear strobe, the select field and the disable code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or watchdog) |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [7:4] disable code, [3:2] prescaler select, [1] clear strobe |
| stop_req | input | 1 | Request to enter the stop state |
| wake_irq | input | 1 | External interrupt that wakes the part from stop |
| cpu_clk_en | output | 1 | CPU clock enable, low in stop and during settling |
| rst_req | output | 1 | One-cycle system reset request on watchdog expiry |

## Verification
The checker assumes that the prescale ratios are at least 2. It also assumes that the surrounding chip pulses wake_irq only while the block is in stop and pulses stop_req only while cpu_clk_en is high. The bench drives every strobe for a single cycle at a fixed offset after the clock edge and follows those rules. The one exception is a control write made while the clock is gated, which checks that such a write is ignored. The bench shrinks the four prescale ratios through parameters, so that each overflow and settling interval can be timed to the exact cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2
  } wd_state_e;

  localparam logic [3:0] WD_OFF_CODE = 4'b1010;

  // Watchdog armed for every nibble except the single disable code.
  function automatic logic wd_armed(input logic [3:0] code);
    return code != WD_OFF_CODE;
  endfunction

  // Prescale ratio chosen by the 2-bit select field.
  function automatic int unsigned pick_div(input logic [1:0] sel,
                                           input int unsigned d0, input int unsigned d1,
                                           input int unsigned d2, input int unsigned d3);
    case (sel)
      2'd0:    return d0;
      2'd1:    return d1;
      2'd2:    return d2;
      default: return d3;
    endcase
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CODE_LO = 4,
  parameter int unsigned SEL_LO  = 2,
  parameter int unsigned CLR_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [3:0]        wd_code,
  output logic [1:0]        div_sel,
  output logic              clr_stb
);

  // Clear strobe is taken straight from the write and never stored.
  assign clr_stb = wr_en && wdata[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_code <= '0;
      div_sel <= '0;
    end else if (wr_en) begin
      wd_code <= wdata[CODE_LO +: 4];
      div_sel <= wdata[SEL_LO +: 2];
    end
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int unsigned DIV0 = 4096,
  parameter int unsigned DIV1 = 1024,
  parameter int unsigned DIV2 = 128,
  parameter int unsigned DIV3 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       hold,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int unsigned DMAX = max4(DIV0, DIV1, DIV2, DIV3);
  localparam int unsigned PW   = (DMAX > 2) ? $clog2(DMAX) : 1;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  always_comb limit = PW'(pick_div(sel, DIV0, DIV1, DIV2, DIV3) - 1);

  // ">=" keeps a ratio change mid-period from skipping a whole wrap.
  assign tick = !hold && !clr && (pre_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr)    pre_q <= '0;
    else if (!hold)  pre_q <= tick ? '0 : pre_q + 1'b1;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STAB_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             stab_carry
);

  // Events seen on the tick that moves the count past a boundary.
  assign ovf        = tick && (&cnt);
  assign stab_carry = tick && (&cnt[STAB_BIT:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdog_stab.sv
module wdog_stab
  import wdog_pkg::*;
#(
  parameter int unsigned DIV0     = 4096,
  parameter int unsigned DIV1     = 1024,
  parameter int unsigned DIV2     = 128,
  parameter int unsigned DIV3     = 16,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STAB_BIT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       stop_req,
  input  logic       wake_irq,
  output logic       cpu_clk_en,
  output logic       rst_req
);

  wd_state_e        state_q, state_d;
  logic [3:0]       wd_code;
  logic [1:0]       div_sel;
  logic             clr_stb;
  logic             wr_ok;
  logic             wake_clr;
  logic             cnt_clr;
  logic             hold;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             stab_carry;
  logic             wd_fire;

  // Writes only land while the CPU clock runs.
  assign wr_ok    = ctl_wr && (state_q == ST_RUN);
  assign wake_clr = (state_q == ST_STOP) && wake_irq;
  assign cnt_clr  = clr_stb || wake_clr;
  assign hold     = (state_q == ST_STOP);

  wdog_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ok),
    .wdata   (ctl_wdata),
    .wd_code (wd_code),
    .div_sel (div_sel),
    .clr_stb (clr_stb)
  );

  wdog_prescaler #(
    .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .hold  (hold),
    .sel   (div_sel),
    .tick  (tick)
  );

  wdog_counter #(
    .CNT_W (CNT_W), .STAB_BIT (STAB_BIT)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .tick       (tick),
    .cnt        (cnt),
    .ovf        (ovf),
    .stab_carry (stab_carry)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (stop_req)   state_d = ST_STOP;
      ST_STOP: if (wake_irq)   state_d = ST_STAB;
      ST_STAB: if (stab_carry) state_d = ST_RUN;
      default:                 state_d = ST_STAB;
    endcase
  end

  assign wd_fire = ovf && wd_armed(wd_code) && (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STAB;
      rst_req <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_req <= wd_fire;
    end
  end

  assign cpu_clk_en = (state_q == ST_RUN);

endmodule

// File: rtl/wdog_stab_chk.sv
module wdog_stab_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned STAB_BIT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [7:0]       ctl_wdata,
  input logic             stop_req,
  input logic             wake_irq,
  input logic             cpu_clk_en,
  input logic             rst_req,
  input wd_state_e        state_q,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             stab_carry,
  input logic [3:0]       wd_code,
  input logic [1:0]       div_sel
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);  // R5

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ovf));  // R5

  AST_NO_REQ_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && wd_code == 4'b1010) |=> !rst_req);  // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_wdata[1] && cpu_clk_en) |=> (cnt == '0));  // R4

  AST_STOP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && stop_req) |=> !cpu_clk_en);  // R7

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !wake_irq) |=> ($stable(cnt) && !rst_req));  // R7

  AST_WAKE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && wake_irq) |=> (cnt == '0 && !cpu_clk_en));  // R8

  AST_STAB_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STAB && stab_carry) |=>
      (cpu_clk_en && cnt == (CNT_W'(1) << (STAB_BIT + 1))));  // R2

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !cpu_clk_en) |=> ($stable(wd_code) && $stable(div_sel)));  // R9

endmodule

bind wdog_stab wdog_stab_chk #(.CNT_W(CNT_W), .STAB_BIT(STAB_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .ctl_wdata  (ctl_wdata),
  .stop_req   (stop_req),
  .wake_irq   (wake_irq),
  .cpu_clk_en (cpu_clk_en),
  .rst_req    (rst_req),
  .state_q    (state_q),
  .cnt        (cnt),
  .ovf        (ovf),
  .stab_carry (stab_carry),
  .wd_code    (wd_code),
  .div_sel    (div_sel)
);

// File: tb/test_wdog_stab.sv
`timescale 1ns/1ps
module test_wdog_stab;

  localparam int D0 = 64;
  localparam int D1 = 32;
  localparam int D2 = 8;
  localparam int D3 = 4;
  localparam int WRAP = 256;
  localparam int SETTLE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       stop_req = 1'b0;
  logic       wake_irq = 1'b0;
  logic       cpu_clk_en;
  logic       rst_req;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wdog_stab #(.DIV0(D0), .DIV1(D1), .DIV2(D2), .DIV3(D3)) i_wdog_stab (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .stop_req   (stop_req),
    .wake_irq   (wake_irq),
    .cpu_clk_en (cpu_clk_en),
    .rst_req    (rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock edge, then settle just after it.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    step();
    ctl_wr = 1'b1;
    ctl_wdata = d;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic expect_pulse_at(input int n, input string tag);
    int first = -1;
    int hits = 0;
    for (int k = 1; k <= n + 1; k++) begin
      step();
      if (rst_req) begin
        hits++;
        if (first < 0) first = k;
      end
    end
    chk(first == n && hits == 1, tag, first, n);
  endtask

  task automatic expect_pulse_within(input int n, input string tag);
    int first = -1;
    for (int k = 1; k <= n; k++) begin
      step();
      if (rst_req && first < 0) first = k;
    end
    chk(first > 0, tag, first, n);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int hits = 0;
    for (int k = 1; k <= n; k++) begin
      step();
      if (rst_req) hits++;
    end
    chk(hits == 0, tag, hits, 0);
  endtask

  task automatic expect_en_at(input int n, input string tag);
    int first = -1;
    for (int k = 1; k <= n; k++) begin
      step();
      if (cpu_clk_en && first < 0) first = k;
    end
    chk(first == n, tag, first, n);
  endtask

  task automatic t_power_up();
    rst_n = 1'b0;
    repeat (3) step();
    chk(cpu_clk_en == 1'b0, "R1 enable low in reset", cpu_clk_en, 0);
    chk(rst_req == 1'b0, "R1 request low in reset", rst_req, 0);
    rst_n = 1'b1;
    expect_en_at(SETTLE * D0, "R2 settle at DIV0 after reset");
  endtask

  task automatic t_ratios();
    wr(8'h0E);
    expect_pulse_at(WRAP * D3, "R3 R5 select 11 overflow timing");
    wr(8'h0A);
    expect_pulse_at(WRAP * D2, "R3 select 10 overflow timing");
    wr(8'h06);
    expect_pulse_at(WRAP * D1, "R3 select 01 overflow timing");
  endtask

  task automatic t_kick();
    for (int i = 0; i < 5; i++) begin
      wr(8'h0E);
      expect_quiet(WRAP * D3 - 20, "R4 periodic clear holds off request");
    end
  endtask

  task automatic t_disable();
    wr(8'hAE);
    expect_quiet(2 * WRAP * D3 + 50, "R6 code 1010 wraps silently");
    wr(8'h0C);
    expect_pulse_within(WRAP * D3 + 2, "R6 code 0000 re-arms");
    wr(8'hBE);
    expect_pulse_at(WRAP * D3, "R6 code 1011 stays armed");
  endtask

  task automatic t_stop_wake();
    wr(8'h0E);
    step();
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk(cpu_clk_en == 1'b0, "R7 stop gates CPU clock", cpu_clk_en, 0);
    expect_quiet(500, "R7 no request in stop");
    chk(cpu_clk_en == 1'b0, "R7 still gated in stop", cpu_clk_en, 0);
    wr(8'hAE);
    step();
    wake_irq = 1'b1;
    step();
    wake_irq = 1'b0;
    expect_en_at(SETTLE * D3, "R8 settle at programmed rate after wake");
    expect_pulse_at(WRAP * D3 - SETTLE * D3, "R9 gated write ignored, still armed");
  endtask

  task automatic t_reset_again();
    wr(8'hAE);
    rst_n = 1'b0;
    repeat (2) step();
    chk(cpu_clk_en == 1'b0 && rst_req == 1'b0, "R1 outputs low on second reset",
        {cpu_clk_en, rst_req}, 0);
    rst_n = 1'b1;
    expect_en_at(SETTLE * D0, "R1 R2 select back to 00 after reset");
    wr(8'h02);
    expect_pulse_at(WRAP * D0, "R1 watchdog armed after reset");
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_power_up();
    t_ratios();
    t_kick();
    t_disable();
    t_stop_wake();
    t_reset_again();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule